// File: doc/BRIEF.md
# Memory-Mapped Bus to Network Packet Adaptor

This block sits between a memory-mapped bus slave port and one port of a network-on-chip router. Each bus write or read that the block accepts becomes one 77-bit packet. The packet is a single flit that acts as both head and tail, and it goes to the router on the following cycle. Reads and writes share one channel, so routing stays static. Reads may be issued back to back, without waiting for earlier ones to complete. A write completes as soon as it is accepted and returns no data.

A credit counter limits the packets in flight to a parameter (16 by default). It loses one credit for each packet sent and gains one for each credit-return pulse from the router. When a request arrives and no credit is left, the bus is stalled with waitrequest. Response packets from the router go into an input FIFO. Their data field is handed back to the bus in arrival order, one word per cycle, each with a single-cycle data-valid pulse.

Top module: `mm_noc_adaptor`

## Requirements
- R1: An outgoing packet has these fields: bits [3:0] hold memory Y, taken from address bits [COORD_LSB+3:COORD_LSB] (default 24). Bits [7:4] hold memory X, taken from address bits [COORD_LSB+7:COORD_LSB+4]. Bits [38:8] hold bus address bits [30:0]. Bits [70:39] hold the data field. Bit 71 holds the request kind. Bits [73:72] hold the PROC_ID parameter. Bit 74 is 1, marking a head-and-tail flit. Bits [76:75] hold the SVC_LEVEL parameter.
- R2: An accepted write produces a packet with bit 71 = 1 and the write data in bits [70:39].
- R3: An accepted read produces a packet with bit 71 = 0 and zero in bits [70:39].
- R4: A request is accepted in a cycle when read or write is high and a credit is available. For each accepted request, pkt_valid is high for exactly the one following cycle, carrying that request's packet. pkt_valid is low in every other cycle.
- R5: The credit count starts at MAX_CREDITS. bus_waitreq is high exactly when a request is present and the count is zero. A stalled request produces no packet.
- R6: A credit-return pulse adds one credit. A send and a return in the same cycle leave the count unchanged. A return while the count is already MAX_CREDITS is ignored.
- R7: A response with rsp_valid high in cycle t produces bus_rdvalid high in cycle t+2. bus_rdata then equals response bits [70:39]. Responses come out in arrival order, one per cycle.
- R8: Reads are pipelined: consecutive read requests are each accepted in consecutive cycles, with no waitrequest, as long as credits remain.
- R9: Reset (rst_n low at a clock edge) empties the FIFO, restores the count to MAX_CREDITS, and holds pkt_valid and bus_rdvalid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 32 | Bus request address |
| bus_read | input | 1 | Read request |
| bus_write | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_waitreq | output | 1 | Stall: request present but no credit |
| bus_rdata | output | 32 | Returned read data |
| bus_rdvalid | output | 1 | One-cycle pulse qualifying bus_rdata |
| pkt_valid | output | 1 | Outgoing packet strobe |
| pkt_data | output | 77 | Outgoing packet |
| credit_ret | input | 1 | Credit-return pulse from the router |
| rsp_valid | input | 1 | Incoming response packet strobe |
| rsp_data | input | 77 | Incoming response packet |

## Verification
The hardest conditions to reach from the ports are credit exhaustion and the edges of the counter: a send and a return landing in the same cycle, and a return arriving when the counter is already full. The stimulus first sends surplus returns while the counter is full. It then issues a long burst of back-to-back reads until the bus stalls, so a saturation error would show up as a burst of the wrong length. Next it holds a request against zero credits, releases it with one return, and repeats the exhaustion while returns and sends coincide. Response traffic runs alongside, both back to back and with gaps, so that the ordering and the two-cycle latency are checked while packets are also flowing out.

// File: rtl/noc_adapt_pkg.sv
package noc_adapt_pkg;
    localparam int PKT_W  = 77;
    localparam int WORD_W = 32;
    localparam int ADDR_F = 31;

    typedef struct packed {
        logic [1:0]        svc;
        logic              flit_ht;
        logic [1:0]        pid;
        logic              is_wr;
        logic [WORD_W-1:0] data;
        logic [ADDR_F-1:0] addr;
        logic [3:0]        mem_x;
        logic [3:0]        mem_y;
    } noc_pkt_t;
endpackage

// File: rtl/noc_credit_ctr.sv
module noc_credit_ctr #(
    parameter int MAX_CREDITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic send_i,
    input  logic ret_i,
    output logic avail_o
);
    localparam int CW = $clog2(MAX_CREDITS + 1);
    localparam logic [CW-1:0] FULL = CW'(MAX_CREDITS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (send_i && !ret_i) begin
            cnt_d = cnt_q - CW'(1);
        end else if (!send_i && ret_i && (cnt_q != FULL)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= FULL;
        else        cnt_q <= cnt_d;
    end

    assign avail_o = (cnt_q != '0);

    // R6
    credit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    // R6
    credit_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && ret_i) |=> (cnt_q == $past(cnt_q)));
    // R5
    no_send_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_i |-> (cnt_q != '0));
endmodule

// File: rtl/noc_router_tx.sv
module noc_router_tx
    import noc_adapt_pkg::*;
#(
    parameter int         COORD_LSB = 24,
    parameter logic [1:0] PROC_ID   = 2'd1,
    parameter logic [1:0] SVC_LEVEL = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              is_wr_i,
    input  logic [31:0]       addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              pkt_valid_o,
    output logic [PKT_W-1:0]  pkt_o
);
    typedef struct packed {
        logic     vld;
        noc_pkt_t pkt;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = accept_i;
        if (accept_i) begin
            st_d.pkt.svc     = SVC_LEVEL;
            st_d.pkt.flit_ht = 1'b1;
            st_d.pkt.pid     = PROC_ID;
            st_d.pkt.is_wr   = is_wr_i;
            st_d.pkt.data    = is_wr_i ? wdata_i : '0;
            st_d.pkt.addr    = addr_i[ADDR_F-1:0];
            st_d.pkt.mem_x   = addr_i[COORD_LSB+7 -: 4];
            st_d.pkt.mem_y   = addr_i[COORD_LSB+3 -: 4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_valid_o = st_q.vld;
    assign pkt_o       = st_q.pkt;

    // R4
    pkt_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> $past(accept_i));
endmodule

// File: rtl/noc_rsp_fifo.sv
module noc_rsp_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic         empty_o,
    output logic [W-1:0] head_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop, full;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = (st_q.wp == PW'(DEPTH-1)) ? '0 : st_q.wp + PW'(1);
        if (do_pop)  st_d.rp = (st_q.rp == PW'(DEPTH-1)) ? '0 : st_q.rp + PW'(1);
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + CW'(1);
        else if (!do_push && do_pop) st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= din_i;
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full);
endmodule

// File: rtl/noc_bus_tx.sv
module noc_bus_tx #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         empty_i,
    input  logic [W-1:0] head_i,
    output logic         pop_o,
    output logic         rdvalid_o,
    output logic [W-1:0] rdata_o
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } bus_state_t;

    bus_state_t st_d, st_q;

    assign pop_o = !empty_i;

    always_comb begin
        st_d     = st_q;
        st_d.vld = !empty_i;
        if (!empty_i) st_d.dat = head_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdvalid_o = st_q.vld;
    assign rdata_o   = st_q.dat;

    // R7
    rdvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdvalid_o |-> $past(!empty_i));
endmodule

// File: rtl/mm_noc_adaptor.sv
module mm_noc_adaptor
    import noc_adapt_pkg::*;
#(
    parameter int         MAX_CREDITS = 16,
    parameter int         FIFO_DEPTH  = 16,
    parameter int         COORD_LSB   = 24,
    parameter logic [1:0] PROC_ID     = 2'd1,
    parameter logic [1:0] SVC_LEVEL   = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       bus_addr,
    input  logic              bus_read,
    input  logic              bus_write,
    input  logic [31:0]       bus_wdata,
    output logic              bus_waitreq,
    output logic [31:0]       bus_rdata,
    output logic              bus_rdvalid,
    output logic              pkt_valid,
    output logic [PKT_W-1:0]  pkt_data,
    input  logic              credit_ret,
    input  logic              rsp_valid,
    input  logic [PKT_W-1:0]  rsp_data
);
    logic req, avail, accept, pop, fifo_empty;
    logic [WORD_W-1:0] fifo_head;
    noc_pkt_t rsp_pkt;

    assign req         = bus_read || bus_write;
    assign accept      = req && avail;
    assign bus_waitreq = req && !avail;
    assign rsp_pkt     = rsp_data;

    noc_credit_ctr #(.MAX_CREDITS(MAX_CREDITS)) u_credit (
        .clk(clk), .rst_n(rst_n), .send_i(accept), .ret_i(credit_ret), .avail_o(avail)
    );

    noc_router_tx #(.COORD_LSB(COORD_LSB), .PROC_ID(PROC_ID), .SVC_LEVEL(SVC_LEVEL)) u_rtx (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .is_wr_i(bus_write),
        .addr_i(bus_addr), .wdata_i(bus_wdata), .pkt_valid_o(pkt_valid), .pkt_o(pkt_data)
    );

    noc_rsp_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(rsp_valid), .din_i(rsp_pkt.data),
        .pop_i(pop), .empty_o(fifo_empty), .head_o(fifo_head)
    );

    noc_bus_tx #(.W(WORD_W)) u_btx (
        .clk(clk), .rst_n(rst_n), .empty_i(fifo_empty), .head_i(fifo_head),
        .pop_o(pop), .rdvalid_o(bus_rdvalid), .rdata_o(bus_rdata)
    );

    // R5
    stall_no_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_waitreq |=> !pkt_valid);
    // R8
    read_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && avail) |-> !bus_waitreq);
endmodule

// File: tb/mm_noc_adaptor_bench.sv
module mm_noc_adaptor_bench;
    localparam int MAXC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_read = 1'b0, bus_write = 1'b0;
    logic        bus_waitreq, bus_rdvalid, pkt_valid;
    logic [31:0] bus_rdata;
    logic [76:0] pkt_data;
    logic        credit_ret = 1'b0, rsp_valid = 1'b0;
    logic [76:0] rsp_data = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    int          m_cred;
    logic        e_pv;
    logic [76:0] e_pkt;
    logic        e_rv;
    logic [31:0] e_rd;
    logic [31:0] m_q[$];

    always #4 clk = ~clk;

    mm_noc_adaptor u_mm_noc_adaptor (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_read(bus_read),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq),
        .bus_rdata(bus_rdata), .bus_rdvalid(bus_rdvalid), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .credit_ret(credit_ret), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [76:0] act, input logic [76:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [76:0] mk_pkt(input bit wr, input logic [31:0] a, input logic [31:0] d);
        logic [76:0] p;
        p = '0;
        p[3:0]   = a[27:24];
        p[7:4]   = a[31:28];
        p[38:8]  = a[30:0];
        p[70:39] = wr ? d : 32'h0;
        p[71]    = wr;
        p[73:72] = 2'd1;
        p[74]    = 1'b1;
        p[76:75] = 2'd0;
        return p;
    endfunction

    // one cycle: check registered outputs, drive, check waitreq, advance model
    task automatic cyc(input bit rd, input bit wr, input logic [31:0] a, input logic [31:0] d,
                       input bit cr, input bit rv, input logic [31:0] rdat, input string tag);
        bit acc;
        @(negedge clk);
        chk(pkt_valid === e_pv, {tag, " R4 pkt_valid"}, 77'(pkt_valid), 77'(e_pv));
        if (e_pv) chk(pkt_data === e_pkt, {tag, " R1 pkt_data"}, pkt_data, e_pkt);
        chk(bus_rdvalid === e_rv, {tag, " R7 rdvalid"}, 77'(bus_rdvalid), 77'(e_rv));
        if (e_rv) chk(bus_rdata === e_rd, {tag, " R7 rdata"}, 77'(bus_rdata), 77'(e_rd));
        bus_read = rd; bus_write = wr; bus_addr = a; bus_wdata = d;
        credit_ret = cr; rsp_valid = rv;
        rsp_data = {6'h0, rdat, 39'h5a5a5a5a5};
        #1;
        chk(bus_waitreq === ((rd || wr) && m_cred == 0), {tag, " R5 waitreq"},
            77'(bus_waitreq), 77'((rd || wr) && m_cred == 0));
        acc   = (rd || wr) && m_cred > 0;
        e_pv  = acc;
        if (acc) e_pkt = mk_pkt(wr, a, d);
        if (acc && !cr) m_cred--;
        else if (!acc && cr && m_cred < MAXC) m_cred++;
        e_rv = (m_q.size() > 0);
        if (e_rv) e_rd = m_q.pop_front();
        if (rv) m_q.push_back(rdat);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_read = 0; bus_write = 0; credit_ret = 0; rsp_valid = 0;
        repeat (2) @(negedge clk);
        chk(pkt_valid === 1'b0, "R9 pkt_valid in reset", 77'(pkt_valid), 77'(0));
        chk(bus_rdvalid === 1'b0, "R9 rdvalid in reset", 77'(bus_rdvalid), 77'(0));
        rst_n = 1'b1;
        m_cred = MAXC; e_pv = 0; e_rv = 0; m_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 R1 writes with varied coordinates
        cyc(0, 1, 32'h3A00_1234, 32'hDEAD_BEEF, 0, 0, 0, "R2 write");
        cyc(0, 1, 32'hC500_0010, 32'h0123_4567, 0, 0, 0, "R2 write2");
        // R3 reads
        cyc(1, 0, 32'h7F00_00A0, 32'hFFFF_FFFF, 0, 0, 0, "R3 read");
        // R10-free idle, credits back
        cyc(0, 0, 0, 0, 1, 0, 0, "R6 ret");
        cyc(0, 0, 0, 0, 1, 0, 0, "R6 ret");
        cyc(0, 0, 0, 0, 1, 1, 32'h1111_0001, "R7 rsp");
        // R6 surplus returns while full are ignored
        cyc(0, 0, 0, 0, 1, 1, 32'h1111_0002, "R6 sat");
        cyc(0, 0, 0, 0, 1, 0, 0, "R6 sat");
        idle(2, "R7 drain");
        // R8 burst of reads until stall
        for (int i = 0; i < MAXC + 2; i++)
            cyc(1, 0, 32'h1200_0000 + 32'(i * 4), 0, 0, (i % 3) != 0, 32'hA000_0000 + 32'(i), "R8 burst");
        // R5 stalled write held, then released by one return
        cyc(0, 1, 32'h2200_0040, 32'hCAFE_0001, 0, 0, 0, "R5 stall");
        cyc(0, 1, 32'h2200_0040, 32'hCAFE_0001, 1, 0, 0, "R5 release");
        cyc(0, 1, 32'h2200_0040, 32'hCAFE_0001, 0, 0, 0, "R5 accepted");
        // R6 send plus return at zero-edge
        cyc(0, 0, 0, 0, 1, 0, 0, "R6 ret");
        cyc(1, 0, 32'h9900_0008, 0, 1, 0, 0, "R6 both");
        cyc(1, 0, 32'h9900_000C, 0, 1, 0, 0, "R6 both");
        cyc(1, 0, 32'h9900_0010, 0, 0, 0, 0, "R6 after");
        // return all credits, response gaps
        for (int i = 0; i < MAXC + 2; i++)
            cyc(0, 0, 0, 0, 1, (i % 2) == 0, 32'hB000_0000 + 32'(i), "R7 gaps");
        idle(3, "R7 drain");
        // R9 reset mid-traffic
        for (int i = 0; i < 10; i++) cyc(1, 0, 32'h4400_0000 + 32'(i), 0, 0, 1, 32'(i), "R9 pre");
        do_reset();
        for (int i = 0; i < MAXC + 1; i++) cyc(0, 1, 32'h5500_0000 + 32'(i), 32'(i), 0, 0, 0, "R9 credits");
        idle(2, "R9 end");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule